// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This unit performs the arithmetic, logic and shift work of a small sound-processor CPU. Each cycle it takes two byte operands, the current carry, a 4-bit operation code and, when asked, a 16-bit word. One clock edge later it presents a byte result and five status flags. Each output comes with its own write enable.

The enables let the register stage that owns the status word update only the flags that the operation defines. Flags the operation does not touch keep their old value in that register. A compare produces flags but asks for no result write-back. A separate word-check input overrides the operation and evaluates negative and zero over a full 16-bit word, for use with word-sized results computed elsewhere.

Top module: `alu8_flagged`

## Requirements
- R1: Operation code 0 (add with carry) returns the low byte of a + b + carry_in, with C set when the 9-bit sum is 0x100 or more. All five flags and the result are written.
- R2: For add, V is set when both operands share a sign bit and the result sign differs from it, and H is set when the low nibbles plus carry_in exceed 0xF.
- R3: Operation code 1 (subtract with borrow) returns the low byte of a - b + carry_in - 1, with C set when that signed difference is zero or more. All five flags and the result are written.
- R4: For subtract, V is set when the operand sign bits differ and the result sign differs from a, and H is set when the low-nibble difference (a - b + carry_in - 1 over bits 3..0) does not borrow.
- R5: Operation code 2 (compare) evaluates a - b regardless of carry_in. It drives the difference's low byte on the result port with the result write enable low, sets C when a >= b unsigned, and writes only N, Z and C.
- R6: Operation codes 3, 4 and 5 (OR, AND, exclusive OR) write the result and only N and Z.
- R7: Operation code 6 shifts left with old bit 7 going to C and 0 into bit 0; code 7 shifts right with old bit 0 going to C and 0 into bit 7. Operand b is ignored. Result, N, Z and C are written.
- R8: Operation code 8 rotates left through carry (carry_in into bit 0, old bit 7 to C); code 9 rotates right through carry (carry_in into bit 7, old bit 0 to C). Result, N, Z and C are written.
- R9: When the word-check input is high, the operation code is ignored. Z is set only when all 16 bits of the word are zero, N equals word bit 15, only N and Z are written, and the result is 0 with its write enable low.
- R10: The flag and flag-enable vectors place N at bit 4, V at bit 3, H at bit 2, Z at bit 1 and C at bit 0. A flag whose enable is low is driven 0. For byte results, N is result bit 7 and Z is set when the result is zero.
- R11: Operation codes 10 to 15 write nothing: all enables are low and result and flags are 0.
- R12: All outputs are registered, appear one clock after the inputs are sampled, and are 0 while the active-low reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Carry in |
| word_chk_i | input | 1 | Request 16-bit N/Z evaluation of word_i |
| word_i | input | 16 | Word to evaluate |
| res_o | output | 8 | Registered result byte |
| res_we_o | output | 1 | Result write enable |
| flags_o | output | 5 | Flags {N,V,H,Z,C} |
| flag_we_o | output | 5 | Per-flag write enables, same layout |

## Verification
The assertions compare each registered output with the inputs seen one edge earlier. They rely on an armed bit that becomes true one cycle after reset release, and on inputs that are fully driven (never X) on every edge, including during reset. The stimulus is driven on the falling edge from a defined all-zero state, so every input is settled and known well before each rising edge. The checks sample on the next falling edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_CMP = 4'd2,
        OP_OR  = 4'd3,
        OP_AND = 4'd4,
        OP_EOR = 4'd5,
        OP_ASL = 4'd6,
        OP_LSR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_OR  = 2'd0,
        LG_AND = 2'd1,
        LG_EOR = 2'd2
    } logic_sel_e;

    localparam int NFLAGS = 5;
    localparam int FL_N   = 4;
    localparam int FL_V   = 3;
    localparam int FL_H   = 2;
    localparam int FL_Z   = 1;
    localparam int FL_C   = 0;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          half_o,
    output logic          ovf_o
);
    localparam int HB = DW / 2;

    logic [DW-1:0] b_eff;
    logic [DW:0]   full;
    logic [HB:0]   low;

    // Subtraction reuses the adder: a + ~b + carry, carry meaning "no borrow".
    assign b_eff  = sub_i ? ~b_i : b_i;
    assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
    assign low    = {1'b0, a_i[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, cin_i};
    assign sum_o  = full[DW-1:0];
    assign cout_o = full[DW];
    assign half_o = low[HB];
    assign ovf_o  = ~(a_i[DW-1] ^ b_eff[DW-1]) & (a_i[DW-1] ^ full[DW-1]);

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic          cin_i,
    input  logic          left_i,
    input  logic          rotate_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    logic fill;

    assign fill = rotate_i & cin_i;

    always_comb begin
        if (left_i) begin
            res_o  = {a_i[DW-2:0], fill};
            cout_o = a_i[DW-1];
        end else begin
            res_o  = {fill, a_i[DW-1:1]};
            cout_o = a_i[0];
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic_sel_e    sel_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  res_o = a_i & b_i;
            LG_EOR:  res_o = a_i ^ b_i;
            default: res_o = a_i | b_i;
        endcase
    end

endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    input  logic             c_i,
    input  logic             word_chk_i,
    input  logic [2*DW-1:0]  word_i,
    output logic [DW-1:0]    res_o,
    output logic             res_we_o,
    output logic [NFLAGS-1:0] flags_o,
    output logic [NFLAGS-1:0] flag_we_o
);
    localparam int WW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0]     res;
        logic              res_we;
        logic [NFLAGS-1:0] flg;
        logic [NFLAGS-1:0] we;
    } stage_t;

    alu_op_e    op;
    logic       as_sub, as_cin, as_c, as_h, as_v;
    logic [DW-1:0] as_res, sh_res, lg_res;
    logic       sh_left, sh_rot, sh_c;
    logic_sel_e lg_sel;
    stage_t     st_d, st_q;
    logic       armed_q;

    assign op     = alu_op_e'(op_i);
    assign as_sub = (op != OP_ADC);
    assign as_cin = (op == OP_CMP) ? 1'b1 : c_i;
    assign sh_left = (op == OP_ASL) || (op == OP_ROL);
    assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

    always_comb begin
        unique case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_EOR:  lg_sel = LG_EOR;
            default: lg_sel = LG_OR;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a_i(a_i), .b_i(b_i), .sub_i(as_sub), .cin_i(as_cin),
        .sum_o(as_res), .cout_o(as_c), .half_o(as_h), .ovf_o(as_v)
    );

    alu8_shifter #(.DW(DW)) u_shift (
        .a_i(a_i), .cin_i(c_i), .left_i(sh_left), .rotate_i(sh_rot),
        .res_o(sh_res), .cout_o(sh_c)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .res_o(lg_res)
    );

    always_comb begin
        st_d = '0;
        if (word_chk_i) begin
            st_d.flg[FL_N] = word_i[WW-1];
            st_d.flg[FL_Z] = (word_i == '0);
            st_d.we[FL_N]  = 1'b1;
            st_d.we[FL_Z]  = 1'b1;
        end else begin
            unique case (op)
                OP_ADC, OP_SBC: begin
                    st_d.res       = as_res;
                    st_d.res_we    = 1'b1;
                    st_d.flg[FL_V] = as_v;
                    st_d.flg[FL_H] = as_h;
                    st_d.flg[FL_C] = as_c;
                    st_d.we        = '1;
                end
                OP_CMP: begin
                    st_d.res       = as_res;
                    st_d.flg[FL_C] = as_c;
                    st_d.we[FL_C]  = 1'b1;
                    st_d.we[FL_N]  = 1'b1;
                    st_d.we[FL_Z]  = 1'b1;
                end
                OP_OR, OP_AND, OP_EOR: begin
                    st_d.res      = lg_res;
                    st_d.res_we   = 1'b1;
                    st_d.we[FL_N] = 1'b1;
                    st_d.we[FL_Z] = 1'b1;
                end
                OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                    st_d.res       = sh_res;
                    st_d.res_we    = 1'b1;
                    st_d.flg[FL_C] = sh_c;
                    st_d.we[FL_C]  = 1'b1;
                    st_d.we[FL_N]  = 1'b1;
                    st_d.we[FL_Z]  = 1'b1;
                end
                default: st_d = '0;
            endcase
            if (st_d.we[FL_N]) begin
                st_d.flg[FL_N] = st_d.res[DW-1];
                st_d.flg[FL_Z] = (st_d.res == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            armed_q <= 1'b1;
        end
    end

    assign res_o     = st_q.res;
    assign res_we_o  = st_q.res_we;
    assign flags_o   = st_q.flg;
    assign flag_we_o = st_q.we;

    // R2: signed overflow seen from the operand and result signs
    p_add_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd0 && !$past(word_chk_i)) |->
        flags_o[FL_V] == (($past(a_i[DW-1]) == $past(b_i[DW-1])) && (res_o[DW-1] != $past(a_i[DW-1]))));

    // R5: compare stores nothing, carry is the unsigned a >= b relation
    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd2 && !$past(word_chk_i)) |->
        (!res_we_o && !flag_we_o[FL_V] && !flag_we_o[FL_H] && flags_o[FL_C] == ($past(a_i) >= $past(b_i))));

    // R6: logic operations enable only N and Z
    p_logic_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd3 && $past(op_i) <= 4'd5 && !$past(word_chk_i)) |->
        (flag_we_o == 5'b10010));

    // R7: shift left sends the old top bit to carry
    p_asl_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 4'd6 && !$past(word_chk_i)) |->
        (flags_o[FL_C] == $past(a_i[DW-1]) && res_o[0] == 1'b0));

    // R9: word check looks at all sixteen bits
    p_word_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(word_chk_i)) |->
        (flags_o[FL_Z] == ($past(word_i) == '0) && flags_o[FL_N] == $past(word_i[WW-1]) && !res_we_o));

    // R10: a flag without its enable is driven low
    p_flag_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~flag_we_o) == '0);

    // R11: unused codes write nothing
    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) > 4'd9 && !$past(word_chk_i)) |->
        (flag_we_o == '0 && !res_we_o));

endmodule

// File: tb/alu8_flagged_tb.sv
module alu8_flagged_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic        c_i = 1'b0;
    logic        word_chk_i = 1'b0;
    logic [15:0] word_i = '0;
    logic [7:0]  res_o;
    logic        res_we_o;
    logic [4:0]  flags_o;
    logic [4:0]  flag_we_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alu8_flagged dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .word_chk_i(word_chk_i), .word_i(word_i), .res_o(res_o), .res_we_o(res_we_o),
        .flags_o(flags_o), .flag_we_o(flag_we_o)
    );

    // entry: {op, a, b, cin, res, res_we, flags{N,V,H,Z,C}, enables}
    localparam int NVEC = 18;
    localparam logic [39:0] VEC [NVEC] = '{
        {4'h0, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 5'b11100, 5'b11111}, // R2 overflow + half
        {4'h0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 5'b00111, 5'b11111}, // R1 carry out, Z
        {4'h0, 8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 5'b00000, 5'b11111}, // R1 carry in
        {4'h1, 8'h50, 8'h10, 1'b1, 8'h40, 1'b1, 5'b00101, 5'b11111}, // R3 no borrow, R4 H
        {4'h1, 8'h00, 8'h01, 1'b1, 8'hFF, 1'b1, 5'b10000, 5'b11111}, // R3 borrow
        {4'h1, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 5'b01001, 5'b11111}, // R4 overflow
        {4'h1, 8'h05, 8'h05, 1'b0, 8'hFF, 1'b1, 5'b10000, 5'b11111}, // R3 carry_in 0
        {4'h2, 8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 5'b00011, 5'b10011}, // R5 equal
        {4'h2, 8'h10, 8'h20, 1'b1, 8'hF0, 1'b0, 5'b10000, 5'b10011}, // R5 less
        {4'h3, 8'hF0, 8'h0F, 1'b1, 8'hFF, 1'b1, 5'b10000, 5'b10010}, // R6 OR
        {4'h4, 8'hF0, 8'h0F, 1'b1, 8'h00, 1'b1, 5'b00010, 5'b10010}, // R6 AND
        {4'h5, 8'hAA, 8'h55, 1'b0, 8'hFF, 1'b1, 5'b10000, 5'b10010}, // R6 EOR
        {4'h6, 8'h81, 8'hFF, 1'b1, 8'h02, 1'b1, 5'b00001, 5'b10011}, // R7 ASL
        {4'h7, 8'h01, 8'hFF, 1'b1, 8'h00, 1'b1, 5'b00011, 5'b10011}, // R7 LSR
        {4'h8, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 5'b00001, 5'b10011}, // R8 ROL
        {4'h9, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 5'b10001, 5'b10011}, // R8 ROR
        {4'h9, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 5'b00010, 5'b10011}, // R8 ROR zero
        {4'hC, 8'h33, 8'h44, 1'b1, 8'h00, 1'b0, 5'b00000, 5'b00000}  // R11 unused
    };

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R5";
            4'd3, 4'd4, 4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            default: return "R11";
        endcase
    endfunction

    // Reference from the requirements; R10 layout {N,V,H,Z,C}.
    function automatic logic [18:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c);
        int s; int hn; logic [7:0] r; logic rw; logic [4:0] f; logic [4:0] w;
        r = '0; rw = 1'b0; f = '0; w = '0;
        case (op)
            4'd0: begin
                s = int'(a) + int'(b) + int'(c); r = s[7:0]; rw = 1'b1; w = 5'b11111;
                f[0] = (s >= 256);
                f[3] = (a[7] == b[7]) && (r[7] != a[7]);
                hn = int'(a[3:0]) + int'(b[3:0]) + int'(c); f[2] = (hn > 15);
            end
            4'd1: begin
                s = int'(a) - int'(b) + int'(c) - 1; r = s[7:0]; rw = 1'b1; w = 5'b11111;
                f[0] = (s >= 0);
                f[3] = (a[7] != b[7]) && (r[7] != a[7]);
                hn = int'(a[3:0]) - int'(b[3:0]) + int'(c) - 1; f[2] = (hn >= 0);
            end
            4'd2: begin
                s = int'(a) - int'(b); r = s[7:0]; w = 5'b10011; f[0] = (s >= 0);
            end
            4'd3: begin r = a | b; rw = 1'b1; w = 5'b10010; end
            4'd4: begin r = a & b; rw = 1'b1; w = 5'b10010; end
            4'd5: begin r = a ^ b; rw = 1'b1; w = 5'b10010; end
            4'd6: begin r = {a[6:0], 1'b0}; f[0] = a[7]; rw = 1'b1; w = 5'b10011; end
            4'd7: begin r = {1'b0, a[7:1]}; f[0] = a[0]; rw = 1'b1; w = 5'b10011; end
            4'd8: begin r = {a[6:0], c};    f[0] = a[7]; rw = 1'b1; w = 5'b10011; end
            4'd9: begin r = {c, a[7:1]};    f[0] = a[0]; rw = 1'b1; w = 5'b10011; end
            default: ;
        endcase
        if (w[4]) begin
            f[4] = r[7];
            f[1] = (r == 8'h00);
        end
        return {r, rw, f, w};
    endfunction

    task automatic check(string req, logic [18:0] exp);
        logic [18:0] got;
        got = {res_o, res_we_o, flags_o, flag_we_o};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got res=%02h rwe=%b flg=%05b we=%05b, expected res=%02h rwe=%b flg=%05b we=%05b",
                     req, got[18:11], got[10], got[9:5], got[4:0],
                     exp[18:11], exp[10], exp[9:5], exp[4:0]);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c,
                         logic wchk, logic [15:0] w);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; c_i = c; word_chk_i = wchk; word_i = w;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        // R12: reset holds outputs at zero even with live inputs
        op_i = 4'd0; a_i = 8'hFF; b_i = 8'h01;
        repeat (3) @(negedge clk);
        check("R12", 19'd0);
        @(negedge clk);
        op_i = '0; a_i = '0; b_i = '0;
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][39:36], VEC[i][35:28], VEC[i][27:20], VEC[i][19], 1'b0, 16'h0);
            check(req_of(VEC[i][39:36]), VEC[i][18:0]);
        end

        // R9: word check, whole word matters and opcode is ignored
        apply(4'd0, 8'hFF, 8'h01, 1'b1, 1'b1, 16'h0000);
        check("R9", {8'h00, 1'b0, 5'b00010, 5'b10010});
        apply(4'd3, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0100);
        check("R9", {8'h00, 1'b0, 5'b00000, 5'b10010});
        apply(4'd1, 8'h00, 8'h00, 1'b0, 1'b1, 16'h8000);
        check("R9", {8'h00, 1'b0, 5'b10000, 5'b10010});

        // R12: one-cycle latency, back-to-back operations
        @(negedge clk);
        op_i = 4'd0; a_i = 8'h01; b_i = 8'h01; c_i = 1'b0; word_chk_i = 1'b0;
        @(negedge clk);
        check("R12", model(4'd0, 8'h01, 8'h01, 1'b0));
        op_i = 4'd5; a_i = 8'h0F; b_i = 8'h0F;
        @(negedge clk);
        check("R12", model(4'd5, 8'h0F, 8'h0F, 1'b0));

        // R2 R4 R10: random operands across all codes
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op; logic [7:0] a; logic [7:0] b; logic c;
            op = 4'($urandom_range(0, 11));
            a  = 8'($urandom);
            b  = 8'($urandom);
            c  = 1'($urandom);
            apply(op, a, b, c, 1'b0, 16'h0);
            check(req_of(op), model(op, a, b, c));
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

endmodule